// File: doc/BRIEF.md
# Shadow-Steered Dual-Channel Task File

This block holds the ATA-style command block registers of two devices, a master and a slave, that share one 32-bit register window of two words. Behind the window each device has its own copy of every byte field. A one-bit shadow device-select flag steers each access to one of the two copies. The flag is reloaded whenever software writes the device/head byte, and that write picks its own target from the bit being written rather than from the stored flag.

Two byte lanes are split by direction. A write to the features lane stores a features byte, and a read of the same lane returns the selected device's error input. A write to the command lane latches a command byte and pulses a one-cycle issue strobe for the selected device, and a read returns that device's status input. The other six fields read back what was last written to the selected copy. Each copy is exported as ports so that the two device engines can consume it.

The bus is a simple synchronous register port with a word address, four byte enables, write data, and read and write strobes. Read data is registered.

Top module: `tf_dualchan`

## Requirements
- R1: After reset, every field of both copies is zero, the shadow flag is 0 (master), read data is zero, the read-valid flag is low and both issue strobes are low.
- R2: Word address 0 holds, per byte enable bit 0 to 3, these fields: data in bits 7:0, features/error in bits 15:8, sector count in bits 23:16 and starting sector in bits 31:24.
- R3: Word address 1 holds, per byte enable bit 0 to 3, these fields: cylinder low in bits 7:0, cylinder high in bits 15:8, device/head in bits 23:16 and command/status in bits 31:24.
- R4: A write to word 1 with byte enable 2 set loads write-data bit 20 (bit 4 of the device/head byte) into the shadow flag, and stores the device/head byte in the copy given by that same bit.
- R5: Every other lane of that same write is steered by the flag value held before the write.
- R6: With the flag at 0, accesses reach copy 0 (master); with the flag at 1, they reach copy 1 (slave).
- R7: A write to the features lane stores features in the selected copy; a read of that lane returns the selected device's error input.
- R8: A write to the command lane stores the command byte in the selected copy and raises that device's issue strobe for exactly one cycle; a read of that lane returns the selected device's status input.
- R9: Only lanes whose byte enable is set change; a write with no byte enables changes nothing.
- R10: A read strobe yields read data and a high read-valid flag in the next cycle; without a read strobe, read-valid is low and read data holds.
- R11: Word addresses other than 0 and 1 are outside the window: writes there are ignored and reads return zero.
- R12: A read and a write issued in the same cycle return the contents held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High in the cycle after a read strobe |
| dev_sel_o | output | 1 | Current shadow device-select flag |
| ch_err_i | input | 2*LANE_W | Error byte per device (device 1 in upper byte) |
| ch_stat_i | input | 2*LANE_W | Status byte per device (device 1 in upper byte) |
| ch_data_o | output | 2*LANE_W | Data field per device |
| ch_feat_o | output | 2*LANE_W | Features field per device |
| ch_scnt_o | output | 2*LANE_W | Sector count per device |
| ch_ssec_o | output | 2*LANE_W | Starting sector per device |
| ch_cyll_o | output | 2*LANE_W | Cylinder low per device |
| ch_cylh_o | output | 2*LANE_W | Cylinder high per device |
| ch_devh_o | output | 2*LANE_W | Device/head per device |
| ch_cmd_o | output | 2*LANE_W | Latched command per device |
| ch_cmd_stb_o | output | 2 | One-cycle command-issue strobe per device |

## Verification
The flag update and the steering of the remaining lanes meet in one cycle when a single write to word 1 enables the device/head lane together with the cylinder lanes and carries a select bit opposite to the stored flag. The bench provokes this and then reads word 1 under each flag value, expecting the cylinder bytes in the old device's copy and the device/head byte in the new one. A read and a write on the same edge are also issued together; the read must return the pre-write byte and a following read the new one.

// File: rtl/tf_pkg.sv
package tf_pkg;
  // Byte lanes per register word and byte fields per device copy.
  localparam int LANES  = 4;
  localparam int FIELDS = 2 * LANES;
  // The shadow flag is one bit, so there are exactly two copies.
  localparam int NUM_CH = 2;

  // Field index = word * LANES + lane; the decoders rely on this order.
  typedef enum logic [2:0] {
    FLD_DATA = 3'd0,
    FLD_FEAT = 3'd1,
    FLD_SCNT = 3'd2,
    FLD_SSEC = 3'd3,
    FLD_CYLL = 3'd4,
    FLD_CYLH = 3'd5,
    FLD_DEVH = 3'd6,
    FLD_CMD  = 3'd7
  } fld_e;
endpackage

// File: rtl/tf_rst_sync.sv
module tf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/tf_access_dec.sv
module tf_access_dec
  import tf_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [LANES-1:0]         bus_be,
  input  logic                     devh_bit,
  input  logic                     sel_q,
  output logic                     in_win,
  output logic                     sel_we,
  output logic [NUM_CH*FIELDS-1:0] fld_we
);
  logic wr_ok;

  // Window check: every address bit above the word bit must be zero.
  if (ADDR_W > 1) begin : g_win
    assign in_win = ~|bus_addr[ADDR_W-1:1];
  end else begin : g_win_all
    assign in_win = 1'b1;
  end

  assign wr_ok  = bus_wr & in_win;
  assign sel_we = wr_ok & bus_addr[0] & bus_be[int'(FLD_DEVH) % LANES];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar f = 0; f < FIELDS; f++) begin : g_fld
      localparam int WRD = f / LANES;
      localparam int LN  = f % LANES;
      logic tgt;
      // The device/head lane steers itself with the incoming select bit.
      if (f == int'(FLD_DEVH)) begin : g_self
        assign tgt = devh_bit;
      end else begin : g_shadow
        assign tgt = sel_q;
      end
      assign fld_we[c*FIELDS + f] = wr_ok & (bus_addr[0] == 1'(WRD))
                                  & bus_be[LN] & (tgt == 1'(c));
    end
  end
endmodule

// File: rtl/tf_chan_bank.sv
module tf_chan_bank
  import tf_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [FIELDS-1:0]        fld_we,
  input  logic [LANES*LANE_W-1:0]  wdata,
  output logic [FIELDS*LANE_W-1:0] fields_o,
  output logic                     cmd_stb_o
);
  logic [FIELDS*LANE_W-1:0] fld_d;
  logic [FIELDS*LANE_W-1:0] fld_q;
  logic                     fld_en;
  logic                     stb_d;
  logic                     stb_q;

  always_comb begin
    fld_d  = fld_q;
    fld_en = |fld_we;
    for (int f = 0; f < FIELDS; f++) begin
      if (fld_we[f]) begin
        fld_d[f*LANE_W +: LANE_W] = wdata[(f % LANES)*LANE_W +: LANE_W];
      end
    end
    stb_d = fld_we[FLD_CMD];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= '0;
    end else if (fld_en) begin
      fld_q <= fld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
    end
  end

  assign fields_o  = fld_q;
  assign cmd_stb_o = stb_q;
endmodule

// File: rtl/tf_rd_path.sv
module tf_rd_path
  import tf_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_rd,
  input  logic                            in_win,
  input  logic                            rd_word,
  input  logic                            sel_q,
  input  logic [NUM_CH*FIELDS*LANE_W-1:0] fld_all,
  input  logic [NUM_CH*LANE_W-1:0]        err_i,
  input  logic [NUM_CH*LANE_W-1:0]        stat_i,
  output logic [LANES*LANE_W-1:0]         rdata_o,
  output logic                            rvalid_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_comb begin
    rd_mux = '0;
    for (int l = 0; l < LANES; l++) begin
      int fi;
      fi = int'(rd_word) * LANES + l;
      if (fi == int'(FLD_FEAT)) begin
        rd_mux[l*LANE_W +: LANE_W] = err_i[int'(sel_q)*LANE_W +: LANE_W];
      end else if (fi == int'(FLD_CMD)) begin
        rd_mux[l*LANE_W +: LANE_W] = stat_i[int'(sel_q)*LANE_W +: LANE_W];
      end else begin
        rd_mux[l*LANE_W +: LANE_W] =
          fld_all[(int'(sel_q)*FIELDS + fi)*LANE_W +: LANE_W];
      end
    end
    rdata_d = in_win ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/tf_dualchan.sv
module tf_dualchan
  import tf_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int LANE_W  = 8,
  parameter int DEV_BIT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [3:0]                bus_be,
  input  logic [4*LANE_W-1:0]       bus_wdata,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  output logic [4*LANE_W-1:0]       bus_rdata,
  output logic                      bus_rvalid,
  output logic                      dev_sel_o,
  input  logic [2*LANE_W-1:0]       ch_err_i,
  input  logic [2*LANE_W-1:0]       ch_stat_i,
  output logic [2*LANE_W-1:0]       ch_data_o,
  output logic [2*LANE_W-1:0]       ch_feat_o,
  output logic [2*LANE_W-1:0]       ch_scnt_o,
  output logic [2*LANE_W-1:0]       ch_ssec_o,
  output logic [2*LANE_W-1:0]       ch_cyll_o,
  output logic [2*LANE_W-1:0]       ch_cylh_o,
  output logic [2*LANE_W-1:0]       ch_devh_o,
  output logic [2*LANE_W-1:0]       ch_cmd_o,
  output logic [1:0]                ch_cmd_stb_o
);
  localparam int DATA_W   = LANES * LANE_W;
  localparam int BANK_W   = FIELDS * LANE_W;
  localparam int DEVH_POS = (int'(FLD_DEVH) % LANES) * LANE_W + DEV_BIT;

  logic                       rst_sync_n;
  logic                       in_win;
  logic                       sel_we;
  logic                       sel_d;
  logic                       sel_q;
  logic [NUM_CH*FIELDS-1:0]   fld_we;
  logic [NUM_CH*BANK_W-1:0]   fld_all;

  tf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tf_access_dec #(.ADDR_W(ADDR_W)) u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .devh_bit (bus_wdata[DEVH_POS]),
    .sel_q    (sel_q),
    .in_win   (in_win),
    .sel_we   (sel_we),
    .fld_we   (fld_we)
  );

  // Shadow device-select flag: next state and register.
  always_comb begin
    sel_d = sel_q;
    if (sel_we) begin
      sel_d = bus_wdata[DEVH_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q <= 1'b0;
    end else if (sel_we) begin
      sel_q <= sel_d;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    logic [BANK_W-1:0] fields;
    logic              stb;

    tf_chan_bank #(.LANE_W(LANE_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .fld_we    (fld_we[c*FIELDS +: FIELDS]),
      .wdata     (bus_wdata),
      .fields_o  (fields),
      .cmd_stb_o (stb)
    );

    assign fld_all[c*BANK_W +: BANK_W]     = fields;
    assign ch_data_o[c*LANE_W +: LANE_W]   = fields[int'(FLD_DATA)*LANE_W +: LANE_W];
    assign ch_feat_o[c*LANE_W +: LANE_W]   = fields[int'(FLD_FEAT)*LANE_W +: LANE_W];
    assign ch_scnt_o[c*LANE_W +: LANE_W]   = fields[int'(FLD_SCNT)*LANE_W +: LANE_W];
    assign ch_ssec_o[c*LANE_W +: LANE_W]   = fields[int'(FLD_SSEC)*LANE_W +: LANE_W];
    assign ch_cyll_o[c*LANE_W +: LANE_W]   = fields[int'(FLD_CYLL)*LANE_W +: LANE_W];
    assign ch_cylh_o[c*LANE_W +: LANE_W]   = fields[int'(FLD_CYLH)*LANE_W +: LANE_W];
    assign ch_devh_o[c*LANE_W +: LANE_W]   = fields[int'(FLD_DEVH)*LANE_W +: LANE_W];
    assign ch_cmd_o[c*LANE_W +: LANE_W]    = fields[int'(FLD_CMD)*LANE_W +: LANE_W];
    assign ch_cmd_stb_o[c]                 = stb;
  end

  tf_rd_path #(.LANE_W(LANE_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_rd   (bus_rd),
    .in_win   (in_win),
    .rd_word  (bus_addr[0]),
    .sel_q    (sel_q),
    .fld_all  (fld_all),
    .err_i    (ch_err_i),
    .stat_i   (ch_stat_i),
    .rdata_o  (bus_rdata),
    .rvalid_o (bus_rvalid)
  );

  assign dev_sel_o = sel_q;

  if (DATA_W != 32) begin : g_width_guard
    initial $error("tf_dualchan: four lanes must form a 32-bit word");
  end
endmodule

// File: rtl/tf_dualchan_chk.sv
module tf_dualchan_chk #(
  parameter int ADDR_W = 2,
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [3:0]          bus_be,
  input logic                devh_bit,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [4*LANE_W-1:0] bus_rdata,
  input logic                bus_rvalid,
  input logic                dev_sel_o,
  input logic [2*LANE_W-1:0] ch_data_o,
  input logic [2*LANE_W-1:0] ch_cyll_o,
  input logic [2*LANE_W-1:0] ch_devh_o,
  input logic [2*LANE_W-1:0] ch_cmd_o,
  input logic [1:0]          ch_cmd_stb_o
);
  logic win;
  logic devh_wr;
  logic cmd_wr;
  logic any_wr;

  assign win     = (bus_addr >> 1) == '0;
  assign devh_wr = bus_wr && win && bus_addr[0] && bus_be[2];
  assign cmd_wr  = bus_wr && win && bus_addr[0] && bus_be[3];
  assign any_wr  = bus_wr && win && (bus_be != 4'b0000);

  // R4
  devsel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    devh_wr |=> (dev_sel_o == $past(devh_bit)));

  // R6
  devsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !devh_wr |=> $stable(dev_sel_o));

  // R10
  rvalid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (!bus_rvalid && $stable(bus_rdata)));

  // R11
  oow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !win) |=> (bus_rdata == '0));

  // R8
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> ($countones(ch_cmd_stb_o) == 1));

  // R8
  cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (ch_cmd_stb_o == 2'b00));

  // R9
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> ($stable(ch_data_o) && $stable(ch_cyll_o)
                 && $stable(ch_devh_o) && $stable(ch_cmd_o)));
endmodule

bind tf_dualchan tf_dualchan_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .bus_addr     (bus_addr),
  .bus_be       (bus_be),
  .devh_bit     (bus_wdata[DEVH_POS]),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .bus_rvalid   (bus_rvalid),
  .dev_sel_o    (dev_sel_o),
  .ch_data_o    (ch_data_o),
  .ch_cyll_o    (ch_cyll_o),
  .ch_devh_o    (ch_devh_o),
  .ch_cmd_o     (ch_cmd_o),
  .ch_cmd_stb_o (ch_cmd_stb_o)
);

// File: tb/tf_dualchan_test.sv
`timescale 1ns/1ps
module tf_dualchan_test;
  logic        clk;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        dev_sel_o;
  logic [15:0] ch_err_i;
  logic [15:0] ch_stat_i;
  logic [15:0] ch_data_o, ch_feat_o, ch_scnt_o, ch_ssec_o;
  logic [15:0] ch_cyll_o, ch_cylh_o, ch_devh_o, ch_cmd_o;
  logic [1:0]  ch_cmd_stb_o;

  int checks;
  int failures;
  bit done;

  tf_dualchan uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .dev_sel_o(dev_sel_o),
    .ch_err_i(ch_err_i), .ch_stat_i(ch_stat_i), .ch_data_o(ch_data_o),
    .ch_feat_o(ch_feat_o), .ch_scnt_o(ch_scnt_o), .ch_ssec_o(ch_ssec_o),
    .ch_cyll_o(ch_cyll_o), .ch_cylh_o(ch_cylh_o), .ch_devh_o(ch_devh_o),
    .ch_cmd_o(ch_cmd_o), .ch_cmd_stb_o(ch_cmd_stb_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Vector: {wr,rd}[77:76] addr[75:72] be[71:68] wdata[67:36] expect[35:4] req[3:0]
  localparam int NVEC = 22;
  localparam logic [77:0] VEC [NVEC] = '{
    {2'b10, 4'h0, 4'hF, 32'h44332211, 32'h00000000, 4'd2},  // R2 fill copy 0
    {2'b01, 4'h0, 4'h0, 32'h0,        32'h4433E011, 4'd7},  // R7 error byte on read
    {2'b10, 4'h1, 4'h4, 32'h00B00000, 32'h00000000, 4'd4},  // R4 flag to 1
    {2'b10, 4'h0, 4'hF, 32'h88776655, 32'h00000000, 4'd6},  // R6 fill copy 1
    {2'b01, 4'h0, 4'h0, 32'h0,        32'h8877E155, 4'd6},  // R6
    {2'b10, 4'h1, 4'h3, 32'h0000CCDD, 32'h00000000, 4'd3},  // R3
    {2'b01, 4'h1, 4'h0, 32'h0,        32'h51B0CCDD, 4'd3},  // R3 status on read
    {2'b10, 4'h1, 4'h4, 32'h00A00000, 32'h00000000, 4'd4},  // R4 flag to 0
    {2'b01, 4'h1, 4'h0, 32'h0,        32'h50A00000, 4'd4},  // R4
    {2'b10, 4'h0, 4'h1, 32'hFFFFFF99, 32'h00000000, 4'd9},  // R9 one lane
    {2'b01, 4'h0, 4'h0, 32'h0,        32'h4433E099, 4'd9},  // R9
    {2'b10, 4'h0, 4'h0, 32'hFFFFFFFF, 32'h00000000, 4'd9},  // R9 no enables
    {2'b01, 4'h0, 4'h0, 32'h0,        32'h4433E099, 4'd9},  // R9
    {2'b10, 4'h2, 4'hF, 32'hDEBFBEEF, 32'h00000000, 4'd11}, // R11 outside
    {2'b01, 4'h2, 4'h0, 32'h0,        32'h00000000, 4'd11}, // R11 reads zero
    {2'b01, 4'h0, 4'h0, 32'h0,        32'h4433E099, 4'd11}, // R11 untouched
    {2'b10, 4'h1, 4'h7, 32'h00F01234, 32'h00000000, 4'd5},  // R5 mixed write
    {2'b01, 4'h1, 4'h0, 32'h0,        32'h51F0CCDD, 4'd5},  // R5 copy 1 view
    {2'b10, 4'h1, 4'h4, 32'h00A00000, 32'h00000000, 4'd5},  // R5 back to 0
    {2'b01, 4'h1, 4'h0, 32'h0,        32'h50A01234, 4'd5},  // R5 copy 0 view
    {2'b11, 4'h0, 4'h1, 32'h0000005A, 32'h4433E099, 4'd12}, // R12 same edge
    {2'b01, 4'h0, 4'h0, 32'h0,        32'h4433E05A, 4'd12}  // R12 new value
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive after a falling edge, capture on the rising edge,
  // return at the next falling edge with strobes released.
  task automatic bus_op(input logic wr, input logic rd, input logic [1:0] a,
                        input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_be = be; bus_wdata = wd;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_be = 4'h0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic check_reset_state();
    // R1
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 rvalid", {31'b0, bus_rvalid}, 32'h0);
    chk("R1 flag", {31'b0, dev_sel_o}, 32'h0);
    chk("R1 fields a", {ch_data_o, ch_feat_o} | {ch_scnt_o, ch_ssec_o}, 32'h0);
    chk("R1 fields b", {ch_cyll_o, ch_cylh_o} | {ch_devh_o, ch_cmd_o}, 32'h0);
    chk("R1 strobes", {30'b0, ch_cmd_stb_o}, 32'h0);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_be = '0; bus_wdata = '0;
    ch_err_i = 16'hE1E0; ch_stat_i = 16'h5150;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state();

    for (int i = 0; i < NVEC; i++) begin
      logic [77:0] v;
      v = VEC[i];
      bus_op(v[77], v[76], v[73:72], v[71:68], v[67:36]);
      if (v[76]) begin
        chk($sformatf("R%0d vec%0d rdata", v[3:0], i), bus_rdata, v[35:4]);
        // R10 valid one cycle after the read strobe
        chk($sformatf("R10 vec%0d rvalid", i), {31'b0, bus_rvalid}, 32'h1);
      end
    end

    // R10 data holds and valid drops without a read
    idle();
    chk("R10 hold rdata", bus_rdata, 32'h4433E05A);
    chk("R10 rvalid low", {31'b0, bus_rvalid}, 32'h0);

    // R7 features stored per copy; R4 device/head per copy; R5 cylinders in copy 0
    chk("R7 features", {16'h0, ch_feat_o}, 32'h00006622);
    chk("R4 devh copies", {16'h0, ch_devh_o}, 32'h0000F0A0);
    chk("R5 cylinder copy0", {ch_cylh_o, ch_cyll_o}, 32'hCC12DD34);
    chk("R6 data copies", {16'h0, ch_data_o}, 32'h0000555A);

    // R8 command to copy 0: strobe for exactly one cycle
    bus_op(1'b1, 1'b0, 2'd1, 4'h8, 32'hEC000000);
    chk("R8 strobe copy0", {30'b0, ch_cmd_stb_o}, 32'h1);
    chk("R8 cmd copy0", {24'b0, ch_cmd_o[7:0]}, 32'hEC);
    idle();
    chk("R8 strobe drops", {30'b0, ch_cmd_stb_o}, 32'h0);

    // R8 command to copy 1 after the flag moves
    bus_op(1'b1, 1'b0, 2'd1, 4'h4, 32'h00100000);
    chk("R4 flag set", {31'b0, dev_sel_o}, 32'h1);
    bus_op(1'b1, 1'b0, 2'd1, 4'h8, 32'hCA000000);
    chk("R8 strobe copy1", {30'b0, ch_cmd_stb_o}, 32'h2);
    chk("R8 cmd copies", {16'h0, ch_cmd_o}, 32'h0000CAEC);
    idle();
    chk("R8 strobe drops 1", {30'b0, ch_cmd_stb_o}, 32'h0);

    // R7 error input follows the device picked by the flag
    ch_err_i = 16'h3C2B;
    bus_op(1'b0, 1'b1, 2'd0, 4'h0, 32'h0);
    chk("R7 error copy1", bus_rdata, 32'h8877_3C55);

    // R1 reset again in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule